// File: doc/BRIEF.md
# Fractional-Rate Digital Quadrature Modulator

This block mixes a stream of interpolated I and Q samples with a digital carrier. It produces one output sample per input sample, at the output sample rate fS. The carrier runs at fS/2, fS/4 or fS/8. At these rates the cosine and sine values come from a tiny exact set: 0, ±1 and ±√2/2, with the last quantised to a fixed Q15 constant. No oscillator or phase accumulator of any width is needed. A three-bit phase index walks through 2, 4 or 8 points.

There are three operating modes. Product mode multiplies I by the cosine and Q by the sine, and each result goes to its own output. Rotation mode forms a full complex rotation of (I, Q) by the carrier angle, so that only one sideband appears. Pass mode sends I and Q to the outputs unchanged.

A sine-sign control flips the sine, which picks the rotation direction and therefore the sideband. A sync input, or any change of rate or mode, restarts the carrier at phase zero. Every result is saturated to 16-bit signed range and registered once.

Top module: `cmix_modulator`

## Requirements
- R1: The `rate_sel` code sets the carrier period. Code 0 gives fS/2 (2 samples), code 1 gives fS/4 (4 samples), and codes 2 and 3 both give fS/8 (8 samples). In every case the phase index k stays below the period.
- R2: At fS/4 the carrier for k = 0..3 is cos = 1, 0, −1, 0 and sin = 0, 1, 0, −1.
- R3: At fS/2 the carrier for k = 0..1 is cos = +1, −1, and the sine is zero at every phase.
- R4: At fS/8 the carrier is cos(2πk/8) and sin(2πk/8) for k = 0..7. Unity is 32768 and √2/2 is 23170, both in Q15. Every product is reduced as floor(x·c / 32768).
- R5: When `mode` = 1 (product), `out_i` = floor(I·cos) and `out_q` = floor(Q·sin).
- R6: When `mode` = 2 (rotation), `out_i` = floor(I·cos − Q·sin) and `out_q` = floor(I·sin + Q·cos). Each sum is formed at full precision before the scaling.
- R7: When `mode` = 0 or 3 (pass), `out_i` = I and `out_q` = Q, whatever the carrier state.
- R8: When `sin_neg` = 1, the sine value used in R5 and R6 is negated.
- R9: A cycle with `sync` high, or with `rate_sel` or `mode` different from the previous cycle, uses k = 0. Each following cycle uses the next k, wrapping at the period.
- R10: Every result is saturated to the range −32768..32767.
- R11: The outputs are registered, so inputs presented in one cycle appear after the next rising edge. Reset clears both outputs to zero and the phase to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Restart carrier at phase zero |
| rate_sel | input | 2 | Carrier rate code (R1) |
| mode | input | 2 | 0/3 pass, 1 product, 2 rotation |
| sin_neg | input | 1 | Negate sine carrier |
| i_in | input | 16 | I sample, two's complement |
| q_in | input | 16 | Q sample, two's complement |
| out_i | output | 16 | First output channel |
| out_q | output | 16 | Second output channel |

## Verification
The bound checker enforces several properties on every cycle:
- the phase index stays inside the selected period;
- sync restarts the phase so that the next sample uses k = 1;
- pass mode reproduces the previous inputs exactly;
- the fS/2 sine lane stays at zero;
- the fS/4 cosine lane is zero at odd phases.

Some behaviour can only be shown by the bench's scenarios, where results are compared against a reference built on real-valued cosine and sine. This covers:
- the exact values of the √2/2 products and their floor rounding;
- the rotation sums and their saturation at full-scale inputs;
- the sine-sign flip;
- the phase restarts caused by a change of rate or mode.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_PROD  = 2'd1,
    MODE_ROT   = 2'd2,
    MODE_PASS2 = 2'd3
  } cmix_mode_e;

  typedef enum logic [1:0] {
    RATE_HALF    = 2'd0,
    RATE_QUARTER = 2'd1,
    RATE_EIGHTH  = 2'd2,
    RATE_EIGHTH2 = 2'd3
  } cmix_rate_e;

  localparam int PHASE_W = 3;

  // last phase index of the selected period
  function automatic logic [PHASE_W-1:0] period_last(input logic [1:0] rate);
    case (rate)
      RATE_HALF:    period_last = 3'd1;
      RATE_QUARTER: period_last = 3'd3;
      default:      period_last = 3'd7;
    endcase
  endfunction

  // map phase index to eighth-turn octant
  function automatic logic [PHASE_W-1:0] to_octant(input logic [1:0] rate,
                                                   input logic [PHASE_W-1:0] k);
    case (rate)
      RATE_HALF:    to_octant = {k[0], 2'b00};
      RATE_QUARTER: to_octant = {k[1:0], 1'b0};
      default:      to_octant = k;
    endcase
  endfunction
endpackage

// File: rtl/cmix_phase.sv
module cmix_phase
  import cmix_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync,
  input  logic [1:0]         rate_sel,
  input  logic [1:0]         mode,
  output logic [PHASE_W-1:0] phase_k,
  output logic               restart
);
  logic [PHASE_W-1:0] k_q;
  logic [1:0]         rate_q;
  logic [1:0]         mode_q;
  logic [PHASE_W-1:0] last_k;

  assign last_k  = period_last(rate_sel);
  assign restart = sync | (rate_sel != rate_q) | (mode != mode_q);
  assign phase_k = restart ? '0 : k_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q    <= '0;
      rate_q <= 2'd0;
      mode_q <= 2'd0;
    end else begin
      k_q    <= (phase_k == last_k) ? '0 : phase_k + 1'b1;
      rate_q <= rate_sel;
      mode_q <= mode;
    end
  end
endmodule

// File: rtl/cmix_carrier.sv
module cmix_carrier
  import cmix_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW = DW + 1
) (
  input  logic [1:0]           rate_sel,
  input  logic [PHASE_W-1:0]   phase_k,
  input  logic                 sin_neg,
  output logic signed [CW-1:0] cos_c,
  output logic signed [CW-1:0] sin_c
);
  localparam int UNITY     = 2 ** (DW - 1);
  localparam int ROOT_HALF = $rtoi((2.0 ** (DW - 1)) * 0.7071067811865476 + 0.5);
  localparam logic signed [CW-1:0] C_ONE  = CW'(UNITY);
  localparam logic signed [CW-1:0] C_ROOT = CW'(ROOT_HALF);

  function automatic logic signed [CW-1:0] octant_cos(input logic [PHASE_W-1:0] j);
    case (j)
      3'd0:    octant_cos = C_ONE;
      3'd1:    octant_cos = C_ROOT;
      3'd2:    octant_cos = '0;
      3'd3:    octant_cos = -C_ROOT;
      3'd4:    octant_cos = -C_ONE;
      3'd5:    octant_cos = -C_ROOT;
      3'd6:    octant_cos = '0;
      default: octant_cos = C_ROOT;
    endcase
  endfunction

  logic [PHASE_W-1:0]   oct;
  logic [PHASE_W-1:0]   oct_sin;
  logic signed [CW-1:0] sin_raw;

  assign oct     = to_octant(rate_sel, phase_k);
  assign oct_sin = oct - 3'd2;        // sin(x) = cos(x - quarter turn)
  assign cos_c   = octant_cos(oct);
  assign sin_raw = octant_cos(oct_sin);
  assign sin_c   = sin_neg ? -sin_raw : sin_raw;
endmodule

// File: rtl/cmix_combine.sv
module cmix_combine
  import cmix_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW   = DW + 1,
  localparam int PW   = DW + CW,
  localparam int ACCW = PW + 1
) (
  input  logic [1:0]           mode,
  input  logic signed [DW-1:0] i_s,
  input  logic signed [DW-1:0] q_s,
  input  logic signed [CW-1:0] cos_c,
  input  logic signed [CW-1:0] sin_c,
  output logic signed [DW-1:0] res_i,
  output logic signed [DW-1:0] res_q
);
  localparam int FRAC = DW - 1;
  localparam logic signed [ACCW-1:0] MAXV = ACCW'(2 ** (DW - 1) - 1);
  localparam logic signed [ACCW-1:0] MINV = -ACCW'(2 ** (DW - 1));

  function automatic logic signed [PW-1:0] mul(input logic signed [DW-1:0] x,
                                               input logic signed [CW-1:0] c);
    mul = PW'(x) * PW'(c);
  endfunction

  function automatic logic signed [DW-1:0] scale_sat(input logic signed [ACCW-1:0] acc);
    logic signed [ACCW-1:0] sh;
    sh = acc >>> FRAC;
    if (sh > MAXV)      scale_sat = MAXV[DW-1:0];
    else if (sh < MINV) scale_sat = MINV[DW-1:0];
    else                scale_sat = sh[DW-1:0];
  endfunction

  logic signed [PW-1:0]   p_ic, p_qs, p_is, p_qc;
  logic signed [ACCW-1:0] acc_i, acc_q;

  assign p_ic = mul(i_s, cos_c);
  assign p_qs = mul(q_s, sin_c);
  assign p_is = mul(i_s, sin_c);
  assign p_qc = mul(q_s, cos_c);

  always_comb begin
    acc_i = ACCW'(p_ic);
    acc_q = ACCW'(p_qs);
    res_i = i_s;
    res_q = q_s;
    case (cmix_mode_e'(mode))
      MODE_PROD: begin
        res_i = scale_sat(acc_i);
        res_q = scale_sat(acc_q);
      end
      MODE_ROT: begin
        acc_i = ACCW'(p_ic) - ACCW'(p_qs);
        acc_q = ACCW'(p_is) + ACCW'(p_qc);
        res_i = scale_sat(acc_i);
        res_q = scale_sat(acc_q);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmix_modulator.sv
module cmix_modulator
  import cmix_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync,
  input  logic [1:0]    rate_sel,
  input  logic [1:0]    mode,
  input  logic          sin_neg,
  input  logic [DW-1:0] i_in,
  input  logic [DW-1:0] q_in,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q
);
  localparam int CW    = DW + 1;
  localparam int LANES = 2;

  logic [PHASE_W-1:0]   phase_k;
  logic                 restart;
  logic signed [CW-1:0] cos_c, sin_c;
  logic signed [DW-1:0] res_i, res_q;
  logic [DW-1:0]        lane_d [LANES];
  logic [DW-1:0]        lane_q [LANES];

  cmix_phase u_phase (
    .clk(clk), .rst_n(rst_n), .sync(sync), .rate_sel(rate_sel),
    .mode(mode), .phase_k(phase_k), .restart(restart)
  );

  cmix_carrier #(.DW(DW)) u_carrier (
    .rate_sel(rate_sel), .phase_k(phase_k), .sin_neg(sin_neg),
    .cos_c(cos_c), .sin_c(sin_c)
  );

  cmix_combine #(.DW(DW)) u_combine (
    .mode(mode), .i_s(signed'(i_in)), .q_s(signed'(q_in)),
    .cos_c(cos_c), .sin_c(sin_c), .res_i(res_i), .res_q(res_q)
  );

  assign lane_d[0] = res_i;
  assign lane_d[1] = res_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[g] <= '0;
      else        lane_q[g] <= lane_d[g];
    end
  end

  assign out_i = lane_q[0];
  assign out_q = lane_q[1];
endmodule

// File: rtl/cmix_checker.sv
module cmix_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sync,
  input logic [1:0]  rate_sel,
  input logic [1:0]  mode,
  input logic [15:0] i_in,
  input logic [15:0] q_in,
  input logic [15:0] out_i,
  input logic [15:0] out_q,
  input logic [2:0]  phase_k,
  input logic        restart
);
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 2'd0 |-> phase_k <= 3'd1) and (rate_sel == 2'd1 |-> phase_k <= 3'd3)); // R1

  AST_SYNC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (restart || phase_k == 3'd1)); // R9

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |=> (out_i == $past(i_in) && out_q == $past(q_in))); // R7

  AST_HALF_SIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && rate_sel == 2'd0) |=> out_q == 16'd0); // R3

  AST_QUARTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && rate_sel == 2'd1 && phase_k[0]) |=> out_i == 16'd0); // R2
endmodule

bind cmix_modulator cmix_checker u_chk (.*);

// File: tb/cmix_modulator_tb.sv
module cmix_modulator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic sync = 0;
  logic [1:0] rate_sel = 0, mode = 0;
  logic sin_neg = 0;
  logic [15:0] i_in = 0, q_in = 0;
  logic [15:0] out_i, out_q;

  int n_tests = 0, n_fail = 0;
  bit have_exp = 0;
  int exp_i, exp_q;
  string exp_tag;
  int ph = 0;
  logic [1:0] prev_r = 0, prev_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmix_modulator dut_i (.*);

  function automatic longint fl(input longint p);
    if (p >= 0) return p / 32768;
    return -((-p + 32767) / 32768);
  endfunction

  function automatic int sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int qcoef(input real r);
    if (r > 0.99) return 32768;
    if (r < -0.99) return -32768;
    if (r > 0.01) return 23170;
    if (r < -0.01) return -23170;
    return 0;
  endfunction

  task automatic chk(input string tag, input int gi, input int gq, input int ei, input int eq);
    n_tests++;
    if (gi != ei || gq != eq) begin
      n_fail++;
      $display("FAIL %s: got i=%0d q=%0d expected i=%0d q=%0d", tag, gi, gq, ei, eq);
    end
  endtask

  task automatic step(input int iv, input int qv, input logic [1:0] r, input logic [1:0] m,
                      input logic sn, input logic sy, input string tag);
    int n, k, c, s;
    bit rs;
    real ang;
    @(negedge clk);
    if (have_exp)
      chk(exp_tag, int'($signed(out_i)), int'($signed(out_q)), exp_i, exp_q);
    n  = (r == 0) ? 2 : (r == 1) ? 4 : 8;
    rs = sy || r != prev_r || m != prev_m;
    k  = rs ? 0 : ph;
    ph = (k + 1) % n;
    prev_r = r; prev_m = m;
    ang = 2.0 * 3.141592653589793 * k / n;
    c = qcoef($cos(ang));
    s = qcoef($sin(ang));
    if (sn) s = -s;
    if (m == 1) begin
      exp_i = sat(fl(longint'(iv) * c));
      exp_q = sat(fl(longint'(qv) * s));
    end else if (m == 2) begin
      exp_i = sat(fl(longint'(iv) * c - longint'(qv) * s));
      exp_q = sat(fl(longint'(iv) * s + longint'(qv) * c));
    end else begin
      exp_i = iv; exp_q = qv;
    end
    exp_tag = tag;
    have_exp = 1;
    i_in = 16'(iv); q_in = 16'(qv);
    rate_sel = r; mode = m; sin_neg = sn; sync = sy;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] rr, mm;
    logic sn;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset", int'($signed(out_i)), int'($signed(out_q)), 0, 0);

    for (int t = 0; t < 4; t++) step(1000, -700, 2'd0, 2'd1, 0, 0, "R3 half rate");
    for (int t = 0; t < 5; t++) step(1234, 4321, 2'd1, 2'd1, 0, 0, "R2 quarter rate");
    for (int t = 0; t < 9; t++) step(10000, -9999, 2'd2, 2'd1, 0, 0, "R4 eighth rate");
    for (int t = 0; t < 9; t++) step(-7777, 3333, 2'd3, 2'd1, 0, 0, "R1 code3 eighth");
    for (int t = 0; t < 4; t++) step(500, 600, 2'd1, 2'd1, 0, 0, "R5 product");
    for (int t = 0; t < 8; t++) step(20000, -15000, 2'd2, 2'd2, 0, 0, "R6 rotation");
    for (int t = 0; t < 4; t++) step(800, 900, 2'd1, 2'd2, 1, 0, "R8 sine flip");
    for (int t = 0; t < 4; t++) step(-32768, 32767, 2'd1, 2'd0, 0, 0, "R7 pass");
    step(111, 222, 2'd1, 2'd1, 0, 0, "R9 pre");
    step(111, 222, 2'd1, 2'd1, 0, 0, "R9 pre");
    step(111, 222, 2'd1, 2'd1, 0, 1, "R9 sync restart");
    step(111, 222, 2'd1, 2'd1, 0, 0, "R9 after sync");
    step(111, 222, 2'd2, 2'd1, 0, 0, "R9 rate change");
    step(111, 222, 2'd2, 2'd2, 0, 0, "R9 mode change");
    for (int t = 0; t < 2; t++) step(-32768, -32768, 2'd0, 2'd1, 0, 0, "R10 neg full scale");
    for (int t = 0; t < 3; t++) step(32767, 32767, 2'd2, 2'd2, 0, 0, "R10 rotation sum");
    for (int t = 0; t < 3; t++) step(-32768, 32767, 2'd1, 2'd2, 1, 0, "R10 rotation corner");

    rr = 2'd1; mm = 2'd1; sn = 0;
    for (int t = 0; t < 600; t++) begin
      int iv, qv;
      if ($urandom % 16 == 0) rr = 2'($urandom);
      if ($urandom % 16 == 0) mm = 2'($urandom);
      if ($urandom % 32 == 0) sn = ~sn;
      iv = int'($signed(16'($urandom)));
      qv = int'($signed(16'($urandom)));
      if ($urandom % 8 == 0) iv = ($urandom % 2) ? 32767 : -32768;
      if ($urandom % 8 == 0) qv = ($urandom % 2) ? 32767 : -32768;
      step(iv, qv, rr, mm, sn, ($urandom % 32 == 0),
           (mm == 1) ? "R5 random" : (mm == 2) ? "R6 random" : "R7 random");
    end
    step(0, 0, 2'd0, 2'd0, 0, 0, "R7 flush");
    @(negedge clk);
    chk(exp_tag, int'($signed(out_i)), int'($signed(out_q)), exp_i, exp_q);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule